// File: doc/BRIEF.md
# Way-Partitioned Banked Cache Tag Controller

This block holds the tags, line-valid bits and replacement state for a banked, 32-way set-associative cache. Several request classes share it: data, texture, instruction and constant. Each bank has its own request lane, so every bank can take one lookup per cycle. For each lookup the block reports hit or miss and the way that hit. On a miss it names a victim way. The data array, the miss path toward memory and coherence live elsewhere. Here a line is represented only by its valid bit and tag.

Each request class has a 32-bit way mask. A lookup can hit in any way of its set. A miss may only replace a way that its class mask enables. Among the enabled ways, an invalid way is taken first. When none is invalid, a tree pseudo-LRU walk picks the victim, and the walk is steered so that it only ends in permitted subtrees. This lets the four classes share each set without evicting each other's lines.

Results are registered one cycle after the request. The client then confirms a fill on the same lane while the miss result is on the outputs. The block writes the new tag and valid bit into the reported victim way at the end of that cycle.

Top module: `wpc_cache_ctrl`

## Requirements
- R1: Lane b serves bank b. Within a request address, bits [5:0] (line offset) and bits [7:6] (bank) take no part in the lookup. Bits [12:8] choose one of the 32 sets, and bits [ADDR_W-1:13] form the tag.
- R2: A request on a lane produces rsp_valid on that lane exactly one clock later. A cycle with no request produces rsp_valid low one clock later.
- R3: When the class mask is non-zero and a valid way in the addressed set holds the request tag, rsp_hit is 1 and rsp_way gives that way, even if the class mask excludes it. If several ways match, the lowest-numbered one is reported.
- R4: On a miss with a non-zero mask, rsp_has_victim is 1. If any way that is enabled in the mask is invalid, the victim is the lowest-numbered such way.
- R5: On a miss where every enabled way is valid, the victim comes from a 31-node binary tree per set. The walk starts at the root. A node value of 1 sends it to the higher-numbered half and 0 to the lower half. If only one half contains an enabled way, the walk goes to that half regardless of the node value.
- R6: When a way is touched in a set, every node on its path is set to point away from it: 0 if the way lies in the node's upper half, 1 if it lies in the lower half. A hit touches the hit way, and an accepted fill touches the victim way.
- R7: fill_valid, asserted in the cycle a lane shows a miss with a victim, writes that lookup's tag into the victim way and marks it valid. Lookups from the next cycle on see the new line.
- R8: fill_valid has no effect unless the lane is showing a valid miss with a victim at that time.
- R9: A request whose class mask is all zeros gives rsp_uncached=1, rsp_hit=0 and rsp_has_victim=0. It changes neither tags, valid bits nor tree state, even when the tag is present.
- R10: The banks are independent. Identical set and tag values on different lanes never affect each other's results or state.
- R11: After reset, every line is invalid, every tree node is 0, and rsp_valid is low on every lane.
- R12: When a lookup and an accepted fill occur on one lane in the same cycle, the lookup sees the state from before the fill. The tree update of the hit is applied first, then that of the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_way_mask | input | NUM_CLASSES*NUM_WAYS | Per-class way masks, class c at bits [c*NUM_WAYS +: NUM_WAYS] |
| req_valid | input | NUM_BANKS | Lookup request per lane |
| req_addr | input | NUM_BANKS*ADDR_W | Request address per lane |
| req_class | input | NUM_BANKS*CLS_W | Class per lane: 0 data, 1 texture, 2 instruction, 3 constant |
| fill_valid | input | NUM_BANKS | Fill confirmation for the victim currently reported |
| rsp_valid | output | NUM_BANKS | Result valid, one cycle after request |
| rsp_hit | output | NUM_BANKS | Lookup hit |
| rsp_uncached | output | NUM_BANKS | Request class mask was zero |
| rsp_has_victim | output | NUM_BANKS | A victim way is reported |
| rsp_way | output | NUM_BANKS*WAY_W | Hitting way |
| rsp_victim | output | NUM_BANKS*WAY_W | Victim way on a miss |

## Verification
The bench keeps the default 4 banks, 32 sets and 32 ways, and sets ADDR_W to 20 so that the tag is 7 bits wide. Its stimulus confines each phase to one or two sets and a few dozen tags. This fills sets quickly, so the pseudo-LRU walk runs under contiguous, sparse, all-zero and all-ones masks, and hits land in ways outside the requester's mask. Phases with a request and a fill in every cycle make the same-cycle ordering of lookup, hit touch and fill visible.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  localparam int CLASS_COUNT = 4;

  typedef enum logic [1:0] {
    CLS_DATA    = 2'd0,
    CLS_TEXTURE = 2'd1,
    CLS_INSTR   = 2'd2,
    CLS_CONST   = 2'd3
  } req_class_e;

  // Index of the lowest set bit; zero when no bit is set.
  function automatic int first_set(input logic [63:0] v);
    int idx;
    idx = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/wpc_plru_touch.sv
// Marks a way as most recently used: every node on its path points away.
module wpc_plru_touch #(
  parameter int WAYS = 32,
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic [NODES-1:0] tree_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [NODES-1:0] tree_o
);

  function automatic logic [NODES-1:0] touch_path(input logic [NODES-1:0] tr,
                                                   input logic [WAY_W-1:0] way);
    logic [NODES-1:0] t;
    int node;
    t = tr;
    node = 0;
    for (int lv = 0; lv < WAY_W; lv++) begin
      logic up;
      up = way[WAY_W-1-lv];
      t[node] = ~up;
      node = 2 * node + 1 + int'(up);
    end
    return t;
  endfunction

  always_comb tree_o = touch_path(tree_i, way_i);

endmodule

// File: rtl/wpc_victim_sel.sv
// Victim choice: lowest invalid permitted way first, else masked tree walk.
module wpc_victim_sel
  import wpc_pkg::*;
#(
  parameter int WAYS = 32,
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic [NODES-1:0] tree_i,
  input  logic [WAYS-1:0]  mask_i,
  input  logic [WAYS-1:0]  valid_i,
  output logic [WAY_W-1:0] victim_o,
  output logic             has_victim_o,
  output logic             from_free_o
);

  // Walk the tree; a half with no permitted way is never entered.
  function automatic logic [WAY_W-1:0] masked_walk(input logic [NODES-1:0] tr,
                                                    input logic [WAYS-1:0] m);
    int node;
    int pfx;
    node = 0;
    pfx = 0;
    for (int lv = 0; lv < WAY_W; lv++) begin
      logic lo_any;
      logic hi_any;
      logic go_hi;
      lo_any = 1'b0;
      hi_any = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        if ((w >> (WAY_W - 1 - lv)) == 2 * pfx)     lo_any = lo_any | m[w];
        if ((w >> (WAY_W - 1 - lv)) == 2 * pfx + 1) hi_any = hi_any | m[w];
      end
      go_hi = hi_any & (~lo_any | tr[node]);
      pfx  = 2 * pfx + int'(go_hi);
      node = 2 * node + 1 + int'(go_hi);
    end
    return WAY_W'(pfx);
  endfunction

  logic [WAYS-1:0]  free_ways;
  logic [WAY_W-1:0] free_pick;
  logic [WAY_W-1:0] tree_pick;

  assign free_ways    = mask_i & ~valid_i;
  assign from_free_o  = |free_ways;
  assign has_victim_o = |mask_i;
  assign free_pick    = WAY_W'(first_set(64'(free_ways)));
  assign tree_pick    = masked_walk(tree_i, mask_i);
  assign victim_o     = from_free_o ? free_pick : tree_pick;

endmodule

// File: rtl/wpc_bank.sv
// One bank: tag/valid/tree state, lookup, registered result and fill.
module wpc_bank
  import wpc_pkg::*;
#(
  parameter int WAYS = 32,
  parameter int SETS = 32,
  parameter int TAG_W = 19,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [SET_W-1:0] req_set_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic [WAYS-1:0]  req_mask_i,
  input  logic             fill_valid_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             rsp_uncached_o,
  output logic             rsp_has_victim_o,
  output logic [WAY_W-1:0] rsp_way_o,
  output logic [WAY_W-1:0] rsp_victim_o,
  output logic             ev_hit_touch_o,
  output logic             ev_fill_o
);

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [NODES-1:0] tree_q [SETS];

  logic             rsp_valid_q, rsp_hit_q, rsp_unc_q, rsp_hasv_q;
  logic [WAY_W-1:0] rsp_way_q, rsp_vic_q;
  logic [SET_W-1:0] rsp_set_q;
  logic [TAG_W-1:0] rsp_tag_q;

  logic [WAYS-1:0]  cur_vld;
  logic [NODES-1:0] cur_tree;
  logic [WAYS-1:0]  hit_vec;
  logic             cacheable;
  logic             lk_hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim;
  logic             victim_ok;
  logic             victim_free;
  logic             hit_touch;
  logic [NODES-1:0] tree_after_hit;
  logic             fill_go;
  logic [NODES-1:0] fill_base;
  logic [NODES-1:0] tree_after_fill;

  assign cur_vld  = vld_q[req_set_i];
  assign cur_tree = tree_q[req_set_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = cur_vld[w] && (tag_q[req_set_i][w] == req_tag_i);
  end

  assign cacheable = |req_mask_i;
  assign lk_hit    = cacheable && (|hit_vec);
  assign hit_way   = WAY_W'(first_set(64'(hit_vec)));
  assign hit_touch = req_valid_i && lk_hit;

  wpc_victim_sel #(.WAYS(WAYS)) u_vsel (
    .tree_i       (cur_tree),
    .mask_i       (req_mask_i),
    .valid_i      (cur_vld),
    .victim_o     (victim),
    .has_victim_o (victim_ok),
    .from_free_o  (victim_free)
  );

  wpc_plru_touch #(.WAYS(WAYS)) u_touch_hit (
    .tree_i (cur_tree),
    .way_i  (hit_way),
    .tree_o (tree_after_hit)
  );

  // Fill acts only on a miss-with-victim result being presented now.
  assign fill_go   = fill_valid_i && rsp_valid_q && !rsp_hit_q && rsp_hasv_q;
  assign fill_base = (hit_touch && (req_set_i == rsp_set_q)) ? tree_after_hit
                                                             : tree_q[rsp_set_q];

  wpc_plru_touch #(.WAYS(WAYS)) u_touch_fill (
    .tree_i (fill_base),
    .way_i  (rsp_vic_q),
    .tree_o (tree_after_fill)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        tree_q[s] <= '0;
      end
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_unc_q   <= 1'b0;
      rsp_hasv_q  <= 1'b0;
      rsp_way_q   <= '0;
      rsp_vic_q   <= '0;
      rsp_set_q   <= '0;
      rsp_tag_q   <= '0;
    end else begin
      if (hit_touch) tree_q[req_set_i] <= tree_after_hit;
      if (fill_go) begin
        tree_q[rsp_set_q]           <= tree_after_fill;
        vld_q[rsp_set_q][rsp_vic_q] <= 1'b1;
      end
      rsp_valid_q <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_q  <= lk_hit;
        rsp_unc_q  <= !cacheable;
        rsp_hasv_q <= victim_ok && !lk_hit;
        rsp_way_q  <= hit_way;
        rsp_vic_q  <= victim;
        rsp_set_q  <= req_set_i;
        rsp_tag_q  <= req_tag_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) tag_q[rsp_set_q][rsp_vic_q] <= rsp_tag_q;
  end

  logic unused_free_flag;
  assign unused_free_flag = victim_free;

  assign rsp_valid_o      = rsp_valid_q;
  assign rsp_hit_o        = rsp_hit_q;
  assign rsp_uncached_o   = rsp_unc_q;
  assign rsp_has_victim_o = rsp_hasv_q;
  assign rsp_way_o        = rsp_way_q;
  assign rsp_victim_o     = rsp_vic_q;
  assign ev_hit_touch_o   = hit_touch;
  assign ev_fill_o        = fill_go;

endmodule

// File: rtl/wpc_cache_ctrl.sv
// Top: address split, class-mask selection and one bank per lane.
module wpc_cache_ctrl
  import wpc_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int NUM_SETS    = 32,
  parameter int NUM_WAYS    = 32,
  parameter int LINE_BYTES  = 64,
  parameter int ADDR_W      = 32,
  parameter int NUM_CLASSES = CLASS_COUNT,
  localparam int CLS_W   = $clog2(NUM_CLASSES),
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int BANK_W  = $clog2(NUM_BANKS),
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int SET_LSB = OFF_W + BANK_W,
  localparam int TAG_LSB = SET_LSB + SET_W,
  localparam int TAG_W   = ADDR_W - TAG_LSB
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_CLASSES*NUM_WAYS-1:0]  cfg_way_mask,
  input  logic [NUM_BANKS-1:0]             req_valid,
  input  logic [NUM_BANKS*ADDR_W-1:0]      req_addr,
  input  logic [NUM_BANKS*CLS_W-1:0]       req_class,
  input  logic [NUM_BANKS-1:0]             fill_valid,
  output logic [NUM_BANKS-1:0]             rsp_valid,
  output logic [NUM_BANKS-1:0]             rsp_hit,
  output logic [NUM_BANKS-1:0]             rsp_uncached,
  output logic [NUM_BANKS-1:0]             rsp_has_victim,
  output logic [NUM_BANKS*WAY_W-1:0]       rsp_way,
  output logic [NUM_BANKS*WAY_W-1:0]       rsp_victim
);

  logic [NUM_BANKS*NUM_WAYS-1:0] lane_mask;
  logic [NUM_BANKS-1:0]          ev_hit_touch;
  logic [NUM_BANKS-1:0]          ev_fill;
  logic [NUM_BANKS*SET_LSB-1:0]  addr_unused_bits;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
    logic [ADDR_W-1:0] addr;
    logic [CLS_W-1:0]  cls;
    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  tag;

    assign addr    = req_addr[b*ADDR_W +: ADDR_W];
    assign cls     = req_class[b*CLS_W +: CLS_W];
    assign set_idx = addr[SET_LSB +: SET_W];
    assign tag     = addr[ADDR_W-1:TAG_LSB];
    assign addr_unused_bits[b*SET_LSB +: SET_LSB] = addr[SET_LSB-1:0];
    assign lane_mask[b*NUM_WAYS +: NUM_WAYS] =
      cfg_way_mask[int'(cls)*NUM_WAYS +: NUM_WAYS];

    wpc_bank #(
      .WAYS  (NUM_WAYS),
      .SETS  (NUM_SETS),
      .TAG_W (TAG_W)
    ) u_bank (
      .clk              (clk),
      .rst_n            (rst_n),
      .req_valid_i      (req_valid[b]),
      .req_set_i        (set_idx),
      .req_tag_i        (tag),
      .req_mask_i       (lane_mask[b*NUM_WAYS +: NUM_WAYS]),
      .fill_valid_i     (fill_valid[b]),
      .rsp_valid_o      (rsp_valid[b]),
      .rsp_hit_o        (rsp_hit[b]),
      .rsp_uncached_o   (rsp_uncached[b]),
      .rsp_has_victim_o (rsp_has_victim[b]),
      .rsp_way_o        (rsp_way[b*WAY_W +: WAY_W]),
      .rsp_victim_o     (rsp_victim[b*WAY_W +: WAY_W]),
      .ev_hit_touch_o   (ev_hit_touch[b]),
      .ev_fill_o        (ev_fill[b])
    );
  end

  logic unused_addr_parity;
  assign unused_addr_parity = ^addr_unused_bits;

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_WAYS  = 32,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_BANKS-1:0]          req_valid,
  input logic [NUM_BANKS-1:0]          rsp_valid,
  input logic [NUM_BANKS-1:0]          rsp_hit,
  input logic [NUM_BANKS-1:0]          rsp_uncached,
  input logic [NUM_BANKS-1:0]          rsp_has_victim,
  input logic [NUM_BANKS*WAY_W-1:0]    rsp_victim,
  input logic [NUM_BANKS*NUM_WAYS-1:0] lane_mask,
  input logic [NUM_BANKS-1:0]          ev_hit_touch,
  input logic [NUM_BANKS-1:0]          ev_fill
);

  logic [NUM_BANKS*NUM_WAYS-1:0] mask_prev;
  always_ff @(posedge clk) mask_prev <= lane_mask;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[b] |=> rsp_valid[b]); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[b] |=> !rsp_valid[b]); // R2
    AST_UNCACHED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[b] && rsp_uncached[b] |-> !rsp_hit[b] && !rsp_has_victim[b]); // R9
    AST_ZERO_MASK_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[b] && (lane_mask[b*NUM_WAYS +: NUM_WAYS] == '0) |=> rsp_uncached[b]); // R9
    AST_MISS_HAS_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[b] && !rsp_hit[b] && !rsp_uncached[b] |-> rsp_has_victim[b]); // R4
    AST_VICTIM_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[b] && rsp_has_victim[b] |->
        mask_prev[b*NUM_WAYS + int'(rsp_victim[b*WAY_W +: WAY_W])]); // R5
    AST_FILL_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_fill[b] |-> rsp_valid[b] && !rsp_hit[b] && rsp_has_victim[b]); // R8
    AST_TOUCH_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      ev_hit_touch[b] |-> req_valid[b] && (lane_mask[b*NUM_WAYS +: NUM_WAYS] != '0)); // R9
  end

endmodule

bind wpc_cache_ctrl wpc_checker #(
  .NUM_BANKS (NUM_BANKS),
  .NUM_WAYS  (NUM_WAYS)
) u_wpc_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .rsp_valid      (rsp_valid),
  .rsp_hit        (rsp_hit),
  .rsp_uncached   (rsp_uncached),
  .rsp_has_victim (rsp_has_victim),
  .rsp_victim     (rsp_victim),
  .lane_mask      (lane_mask),
  .ev_hit_touch   (ev_hit_touch),
  .ev_fill        (ev_fill)
);

// File: tb/tb_wpc_cache_ctrl.sv
`timescale 1ns/1ps
module tb_wpc_cache_ctrl;
  import wpc_pkg::*;

  localparam int NB = 4, NS = 32, NW = 32, AW = 20, NC = 4;
  localparam int CW = 2, WW = 5, SET_LSB = 8, TAG_LSB = 13, TW = AW - TAG_LSB;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC*NW-1:0]  cfg_way_mask = '0;
  logic [NB-1:0]     req_valid = '0;
  logic [NB*AW-1:0]  req_addr = '0;
  logic [NB*CW-1:0]  req_class = '0;
  logic [NB-1:0]     fill_valid = '0;
  logic [NB-1:0]     rsp_valid, rsp_hit, rsp_uncached, rsp_has_victim;
  logic [NB*WW-1:0]  rsp_way, rsp_victim;

  always #10 clk = ~clk;

  wpc_cache_ctrl #(.NUM_BANKS(NB), .NUM_SETS(NS), .NUM_WAYS(NW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_way_mask(cfg_way_mask), .req_valid(req_valid),
    .req_addr(req_addr), .req_class(req_class), .fill_valid(fill_valid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_uncached(rsp_uncached),
    .rsp_has_victim(rsp_has_victim), .rsp_way(rsp_way), .rsp_victim(rsp_victim));

  // Reference state: tree node n (1-based heap), 1 = search goes to upper half.
  int m_tag  [NB][NS][NW];
  bit m_vld  [NB][NS][NW];
  bit m_tree [NB][NS][NW];
  bit e_valid[NB], e_hit[NB], e_unc[NB], e_hasv[NB], e_free[NB];
  int e_way[NB], e_vic[NB], e_set[NB], e_tag[NB];

  int total = 0, fails = 0;
  bit done = 0;
  string phase = "R11 reset";

  function automatic bit any_in(bit [NW-1:0] m, int lo, int hi);
    for (int i = lo; i < hi; i++) if (m[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int m_pick(int b, int s, bit [NW-1:0] m);
    int lo = 0, hi = NW, n = 1;
    while (hi - lo > 1) begin
      int mid = (lo + hi) / 2;
      bit a_lo = any_in(m, lo, mid);
      bit a_hi = any_in(m, mid, hi);
      if (a_hi && (!a_lo || m_tree[b][s][n])) begin lo = mid; n = 2*n + 1; end
      else begin hi = mid; n = 2*n; end
    end
    return lo;
  endfunction

  task automatic m_touch(int b, int s, int w);
    int lo = 0, hi = NW, n = 1;
    while (hi - lo > 1) begin
      int mid = (lo + hi) / 2;
      if (w >= mid) begin m_tree[b][s][n] = 1'b0; lo = mid; n = 2*n + 1; end
      else begin m_tree[b][s][n] = 1'b1; hi = mid; n = 2*n; end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        e_valid[b] = 0;
        for (int s = 0; s < NS; s++)
          for (int w = 0; w < NW; w++) begin m_vld[b][s][w] = 0; m_tree[b][s][w] = 0; end
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        bit nv, nh, nu, nhv, nf;
        int nway, nvic, nset, ntag, cls;
        bit [NW-1:0] msk;
        nv = req_valid[b]; nh = 0; nu = 0; nhv = 0; nf = 0; nway = 0; nvic = 0;
        nset = int'(req_addr[b*AW + SET_LSB +: 5]);
        ntag = int'(req_addr[b*AW + TAG_LSB +: TW]);
        cls  = int'(req_class[b*CW +: CW]);
        msk  = cfg_way_mask[cls*NW +: NW];
        if (nv) begin
          if (msk == 0) nu = 1;
          else begin
            for (int w = 0; w < NW; w++)
              if (!nh && m_vld[b][nset][w] && m_tag[b][nset][w] == ntag) begin nh = 1; nway = w; end
            if (!nh) begin
              nhv = 1; nvic = -1;
              for (int w = 0; w < NW; w++)
                if (nvic < 0 && msk[w] && !m_vld[b][nset][w]) nvic = w;
              if (nvic >= 0) nf = 1; else nvic = m_pick(b, nset, msk);
            end
          end
        end
        if (nv && nh) m_touch(b, nset, nway);
        if (fill_valid[b] && e_valid[b] && !e_hit[b] && e_hasv[b]) begin
          m_tag[b][e_set[b]][e_vic[b]] = e_tag[b];
          m_vld[b][e_set[b]][e_vic[b]] = 1;
          m_touch(b, e_set[b], e_vic[b]);
        end
        e_valid[b] = nv;
        if (nv) begin
          e_hit[b] = nh; e_unc[b] = nu; e_hasv[b] = nhv; e_free[b] = nf;
          e_way[b] = nway; e_vic[b] = nvic; e_set[b] = nset; e_tag[b] = ntag;
        end
      end
    end
  end

  task automatic chk(bit ok, string what, int lane, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL [%s] %s lane %0d: actual %0d expected %0d", phase, what, lane, act, exp);
    end
  endtask

  task automatic compare();
    for (int b = 0; b < NB; b++) begin
      chk(rsp_valid[b] == e_valid[b], "R2 result valid", b, rsp_valid[b], e_valid[b]);
      if (e_valid[b] && rsp_valid[b]) begin
        chk(rsp_uncached[b] == e_unc[b], "R9 uncached flag", b, rsp_uncached[b], e_unc[b]);
        chk(rsp_hit[b] == e_hit[b], "R3 hit flag", b, rsp_hit[b], e_hit[b]);
        if (e_hit[b])
          chk(int'(rsp_way[b*WW +: WW]) == e_way[b], "R3 hit way", b,
              int'(rsp_way[b*WW +: WW]), e_way[b]);
        chk(rsp_has_victim[b] == e_hasv[b], "R4 victim present", b, rsp_has_victim[b], e_hasv[b]);
        if (e_hasv[b])
          chk(int'(rsp_victim[b*WW +: WW]) == e_vic[b],
              e_free[b] ? "R4 invalid-first victim" : "R5 masked tree victim", b,
              int'(rsp_victim[b*WW +: WW]), e_vic[b]);
      end
    end
  endtask

  task automatic run_phase(string tag, int cycles, bit [NB-1:0] lanes, int cls_max,
                           int set_max, int tag_max, int req_pct, int fill_pct,
                           int junk_pct, bit shared);
    phase = tag;
    repeat (cycles) begin
      int st, tg;
      @(negedge clk);
      compare();
      st = int'($urandom % set_max);
      tg = int'($urandom % tag_max);
      for (int b = 0; b < NB; b++) begin
        int s2, t2;
        bit legit;
        s2 = shared ? st : int'($urandom % set_max);
        t2 = shared ? tg : int'($urandom % tag_max);
        req_valid[b] = lanes[b] && (($urandom % 100) < req_pct);
        req_addr[b*AW +: AW] = {TW'(t2), 5'(s2), 2'(b), 6'($urandom % 64)};
        req_class[b*CW +: CW] = CW'($urandom % (cls_max + 1));
        legit = e_valid[b] && !e_hit[b] && e_hasv[b];
        fill_valid[b] = legit ? (($urandom % 100) < fill_pct) : (($urandom % 100) < junk_pct);
      end
    end
  endtask

  initial begin
    cfg_way_mask = {32'h0000_0000, 32'h5A00_0000, 32'h00FF_0000, 32'h0000_FFFF};
    repeat (3) @(negedge clk);
    for (int b = 0; b < NB; b++) chk(rsp_valid[b] == 1'b0, "R11 idle after reset", b, rsp_valid[b], 0);
    rst_n = 1'b1;
    run_phase("R11 R4 cold allocation", 60, 4'b0001, 0, 1, 24, 50, 100, 0, 0);
    run_phase("R5 R6 full-set replacement", 300, 4'b0001, 2, 2, 64, 60, 90, 0, 0);
    run_phase("R3 R6 repeated tags", 200, 4'b0011, 2, 2, 12, 70, 90, 0, 0);
    run_phase("R9 zero-mask class", 200, 4'b1111, 3, 2, 16, 70, 80, 0, 0);
    run_phase("R8 stray fill pulses", 300, 4'b1111, 3, 2, 40, 60, 30, 50, 0);
    run_phase("R10 R1 identical lanes", 200, 4'b1111, 2, 2, 30, 80, 80, 20, 1);
    run_phase("R7 R12 back-to-back fills", 200, 4'b1111, 2, 1, 48, 100, 100, 0, 0);
    cfg_way_mask = {32'h8000_0001, 32'hFFFF_FFFF, 32'h00F0_0F00, 32'h0000_FFFF};
    run_phase("R5 R3 new masks", 300, 4'b1111, 3, 2, 60, 70, 85, 10, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL [%s] R2 watchdog expired", phase);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule